// File: doc/BRIEF.md
# Guarded OTP Configuration Loader

This block runs once after every reset. It fetches two security configuration words from a one-time-programmable array before any processor leaves reset. Each critical word is read between two reads of a known guard location, and the guard pattern is `0x333333`. The guard results tell the loader whether the supply and sensing path were sound while the critical data was being sensed. A guard that reads back wrong makes the critical data untrusted. So does a critical word that reads back exactly as the guard pattern, which is what a sense amplifier holding its last good value would return. Either case spoils the attempt.

The read port is a simple synchronous one. The loader raises a one-cycle strobe with an address, then waits any number of cycles for a data-valid pulse, up to a bounded timeout. A pass over the whole sequence is called an attempt. A failed attempt starts over from the first guard read. After the last permitted attempt fails, the loader locks into a fail-safe state. In that state both cores stay held, debug stays disabled and `fault` is raised until the next reset. A clean attempt decodes the disable bits and publishes them in one cycle, together with `done`.

The state machine has five states:
- `ST_ISSUE` drives the strobe and always moves to `ST_WAIT`.
- `ST_WAIT` moves back to `ST_ISSUE` on a valid response for a non-final slot. It moves to `ST_JUDGE` on a valid response for the final slot, or on a timeout.
- `ST_JUDGE` moves to `ST_DONE` when the attempt was clean. It moves back to `ST_ISSUE` on a failure when attempts remain, and to `ST_LOCK` on a failure of the last attempt.
- `ST_DONE` and `ST_LOCK` are terminal until reset.

Top module: `cfg_guard_loader`

## Requirements
- R1: While reset is applied, `core_a_off`, `core_b_off` and `dbg_off` are 1, and `done` and `fault` are 0.
- R2: Each attempt issues exactly five one-cycle strobes, at addresses BASE+0 through BASE+4 in rising order. Only one read is outstanding at a time, and every attempt starts again at BASE+0.
- R3: The slots BASE+0, BASE+2 and BASE+4 hold guard data. A response from any of them that differs from `0x333333` fails the attempt.
- R4: The slots BASE+1 (critical word 0) and BASE+3 (critical word 1) are critical. A critical response equal to `0x333333` fails the attempt.
- R5: After a clean attempt, `core_a_off` is bit 0 of critical word 0, `core_b_off` is bit 1 of critical word 0, and `dbg_off` is bit 0 of critical word 1. All other bits are ignored.
- R6: If critical word 0 has both bit 0 and bit 1 set, core A stays disabled and core B is released: `core_a_off`=1 and `core_b_off`=0.
- R7: A response accepted on wait cycle 63 after its strobe is used normally. If no valid arrives within 64 wait cycles, the attempt fails.
- R8: A failed attempt is retried from the start, for at most 3 attempts in total. A clean later attempt yields the same outputs as a clean first attempt.
- R9: If all 3 attempts fail, `fault`=1, `done`=1 and all three disable outputs are 1, and this holds until reset.
- R10: Before `done` is 1, all disable outputs stay at 1. They change only in the cycle in which `done` rises, and they stay stable afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| otp_addr | output | 8 | Read address for the OTP array |
| otp_rd | output | 1 | One-cycle read strobe |
| otp_data | input | 24 | Read data, taken when `otp_valid` is 1 |
| otp_valid | input | 1 | Read data valid pulse |
| core_a_off | output | 1 | Hold core A disabled |
| core_b_off | output | 1 | Hold core B disabled |
| dbg_off | output | 1 | Debug access disabled |
| done | output | 1 | Loading finished, outputs are final |
| fault | output | 1 | All attempts failed, fail-safe lockout |

## Verification
The boundary case is the cycle where the wait timer expires. On that cycle a valid response and the timeout can coincide. The bench provokes this by running one case with the response delayed until the 63rd wait cycle, where the data must win and the load must succeed. It runs a second case delayed by one more cycle, where every attempt must time out and the loader must lock. Guard corruption, stale critical data and dropped responses are swept over all eight disable-bit patterns and zero to three failing attempts. The expected outputs and the number of attempts seen on the read port are computed from the requirements.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_ISSUE = 3'd0,
        ST_WAIT  = 3'd1,
        ST_JUDGE = 3'd2,
        ST_DONE  = 3'd3,
        ST_LOCK  = 3'd4
    } ld_state_t;

    typedef struct packed {
        logic core_a_off;
        logic core_b_off;
        logic dbg_off;
    } core_cfg_t;

    localparam core_cfg_t SAFE_CFG = 3'b111;

    // slot order within one attempt: guard, crit0, guard, crit1, guard
    localparam int SEQ_LEN  = 5;
    localparam int CW0_SLOT = 1;
    localparam int CW1_SLOT = 3;

    // bit positions inside the critical words
    localparam int A_BIT   = 0;
    localparam int B_BIT   = 1;
    localparam int DBG_BIT = 0;

endpackage

// File: rtl/cfg_rd_agent.sv
module cfg_rd_agent #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic waiting,
    input  logic rsp_valid,
    output logic timeout
);
    localparam int TMR_W = $clog2(TIMEOUT);
    localparam logic [TMR_W-1:0] LIMIT = TMR_W'(TIMEOUT - 1);

    logic [TMR_W-1:0] timer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (start) begin
            timer <= '0;
        end else if (waiting && !rsp_valid && timer != LIMIT) begin
            timer <= timer + 1'b1;
        end
    end

    assign timeout = waiting && !rsp_valid && (timer == LIMIT);

    // R7
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer == LIMIT && !start) |=> (timer == LIMIT || start || $past(start)));

endmodule

// File: rtl/cfg_word_judge.sv
module cfg_word_judge #(
    parameter int               DATA_W     = 24,
    parameter logic [DATA_W-1:0] GUARD_WORD = 24'h333333
) (
    input  logic              guard_slot,
    input  logic [DATA_W-1:0] data,
    output logic              word_bad
);
    logic is_guard;

    assign is_guard = (data == GUARD_WORD);
    // guard slots must match, critical slots must not look like the guard
    assign word_bad = guard_slot ? !is_guard : is_guard;

endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_loader_pkg::*;
(
    input  logic [1:0] cw0_bits,
    input  logic       cw1_bit,
    output core_cfg_t  cfg
);
    // cw0_bits[0] = core A disable, cw0_bits[1] = core B disable
    always_comb begin
        cfg.core_a_off = cw0_bits[0];
        cfg.core_b_off = cw0_bits[1] && !cw0_bits[0];
        cfg.dbg_off    = cw1_bit;
    end

endmodule

// File: rtl/cfg_guard_loader.sv
module cfg_guard_loader
    import cfg_loader_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h10,
    parameter logic [DATA_W-1:0] GUARD_WORD = 24'h333333,
    parameter int                MAX_TRIES  = 3,
    parameter int                TIMEOUT    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] otp_addr,
    output logic              otp_rd,
    input  logic [DATA_W-1:0] otp_data,
    input  logic              otp_valid,
    output logic              core_a_off,
    output logic              core_b_off,
    output logic              dbg_off,
    output logic              done,
    output logic              fault
);
    localparam int STEP_W = $clog2(SEQ_LEN);
    localparam int TRY_W  = $clog2(MAX_TRIES + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);
    localparam logic [STEP_W-1:0] CW0_STEP  = STEP_W'(CW0_SLOT);
    localparam logic [STEP_W-1:0] CW1_STEP  = STEP_W'(CW1_SLOT);
    localparam logic [TRY_W-1:0]  LAST_TRY  = TRY_W'(MAX_TRIES - 1);

    ld_state_t         state, nxt;
    logic [STEP_W-1:0] step;
    logic [TRY_W-1:0]  tries;
    logic              bad;
    logic [1:0]        cw0_q;
    logic              cw1_q;
    logic              word_bad, timeout, waiting;
    core_cfg_t         dec_cfg, cfg_q;
    logic              done_q, fault_q;

    assign otp_rd   = (state == ST_ISSUE);
    assign waiting  = (state == ST_WAIT);
    assign otp_addr = BASE_ADDR + ADDR_W'(step);

    cfg_rd_agent #(.TIMEOUT(TIMEOUT)) u_agent (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (otp_rd),
        .waiting   (waiting),
        .rsp_valid (otp_valid),
        .timeout   (timeout)
    );

    cfg_word_judge #(.DATA_W(DATA_W), .GUARD_WORD(GUARD_WORD)) u_judge (
        .guard_slot (!step[0]),
        .data       (otp_data),
        .word_bad   (word_bad)
    );

    cfg_decode u_decode (
        .cw0_bits (cw0_q),
        .cw1_bit  (cw1_q),
        .cfg      (dec_cfg)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_ISSUE: nxt = ST_WAIT;
            ST_WAIT: begin
                if (otp_valid) begin
                    nxt = (step == LAST_STEP) ? ST_JUDGE : ST_ISSUE;
                end else if (timeout) begin
                    nxt = ST_JUDGE;
                end
            end
            ST_JUDGE: begin
                if (!bad)                   nxt = ST_DONE;
                else if (tries == LAST_TRY) nxt = ST_LOCK;
                else                        nxt = ST_ISSUE;
            end
            ST_DONE:  nxt = ST_DONE;
            ST_LOCK:  nxt = ST_LOCK;
            default:  nxt = ST_LOCK;
        endcase
    end

    // state register and read sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ISSUE;
            step  <= '0;
            tries <= '0;
            bad   <= 1'b0;
            cw0_q <= '0;
            cw1_q <= 1'b0;
        end else begin
            state <= nxt;
            if (waiting && otp_valid) begin
                bad  <= bad | word_bad;
                step <= step + 1'b1;
                if (step == CW0_STEP) cw0_q <= {otp_data[B_BIT], otp_data[A_BIT]};
                if (step == CW1_STEP) cw1_q <= otp_data[DBG_BIT];
            end else if (waiting && timeout) begin
                bad <= 1'b1;
            end else if (state == ST_JUDGE && nxt == ST_ISSUE) begin
                tries <= tries + 1'b1;
                step  <= '0;
                bad   <= 1'b0;
            end
        end
    end

    // output register: published once, on the final verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= SAFE_CFG;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else if (state == ST_JUDGE) begin
            if (nxt == ST_DONE) begin
                cfg_q  <= dec_cfg;
                done_q <= 1'b1;
            end else if (nxt == ST_LOCK) begin
                done_q  <= 1'b1;
                fault_q <= 1'b1;
            end
        end
    end

    assign core_a_off = cfg_q.core_a_off;
    assign core_b_off = cfg_q.core_b_off;
    assign dbg_off    = cfg_q.dbg_off;
    assign done       = done_q;
    assign fault      = fault_q;

    // R10
    safe_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (core_a_off && core_b_off && dbg_off));

    // R10
    hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable({core_a_off, core_b_off, dbg_off, fault})));

    // R9
    lock_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && core_a_off && core_b_off && dbg_off));

    // R6
    one_core_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> !(core_a_off && core_b_off));

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_rd |=> !otp_rd);

    // R2
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_rd |-> ((otp_addr - BASE_ADDR) < ADDR_W'(SEQ_LEN)));

endmodule

// File: tb/test_cfg_guard_loader.sv
module test_cfg_guard_loader;

    localparam logic [7:0]  BASE  = 8'h10;
    localparam logic [23:0] GUARD = 24'h333333;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  otp_addr;
    logic        otp_rd;
    logic [23:0] otp_data = '0;
    logic        otp_valid = 1'b0;
    logic        core_a_off, core_b_off, dbg_off, done, fault;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    cfg_guard_loader i_cfg_guard_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .otp_addr   (otp_addr),
        .otp_rd     (otp_rd),
        .otp_data   (otp_data),
        .otp_valid  (otp_valid),
        .core_a_off (core_a_off),
        .core_b_off (core_b_off),
        .dbg_off    (dbg_off),
        .done       (done),
        .fault      (fault)
    );

    // OTP model configuration
    logic [23:0] mem [5];
    int          corrupt_n = 0;
    int          kind = 0;
    int          delay = 0;
    // OTP model state
    int          attempts;
    int          last_idx;
    bit          addr_err;
    bit          pending;
    int          cnt;
    int          idx;
    bit          drop;
    logic [23:0] resp;

    always @(negedge clk) begin
        otp_valid = 1'b0;
        if (!rst_n) begin
            pending  = 1'b0;
            attempts = 0;
            last_idx = -1;
            addr_err = 1'b0;
        end else begin
            if (pending) begin
                if (cnt == 0) begin
                    otp_valid = 1'b1;
                    otp_data  = resp;
                    pending   = 1'b0;
                end else begin
                    cnt = cnt - 1;
                end
            end
            if (otp_rd) begin
                idx = int'(otp_addr) - int'(BASE);
                if (idx < 0 || idx > 4) begin
                    addr_err = 1'b1;
                    idx = 0;
                end
                if (idx == 0) attempts = attempts + 1;
                else if (idx != last_idx + 1) addr_err = 1'b1;
                if (pending) addr_err = 1'b1;
                last_idx = idx;
                resp = mem[idx];
                drop = 1'b0;
                if (attempts <= corrupt_n) begin
                    case (kind)
                        0: if (idx == 0) resp = resp ^ 24'h000100;
                        1: if (idx == 2) resp = 24'h000000;
                        2: if (idx == 4) resp = 24'h333330;
                        3: if (idx == 1) resp = GUARD;
                        default: if (idx == 3) drop = 1'b1;
                    endcase
                end
                if (!drop) begin
                    pending = 1'b1;
                    cnt     = delay;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run_case(input logic [23:0] c0, input logic [23:0] c1, input logic [23:0] gmid,
                            input int fails, input int knd, input int dly, input string req);
        bit          perm;
        bit          pre_ok;
        bit          exp_fault;
        int          exp_att;
        logic [2:0]  exp_o, got, snap;
        mem[0] = GUARD; mem[1] = c0; mem[2] = gmid; mem[3] = c1; mem[4] = GUARD;
        corrupt_n = fails; kind = knd; delay = dly;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1
        chk({core_a_off, core_b_off, dbg_off, done, fault} == 5'b11100, "R1",
            {core_a_off, core_b_off, dbg_off, done, fault}, 5'b11100);
        rst_n = 1'b1;
        pre_ok = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done) break;
            if ({core_a_off, core_b_off, dbg_off} != 3'b111) pre_ok = 1'b0;
        end
        perm      = (c0 == GUARD) || (c1 == GUARD) || (gmid != GUARD) || (dly >= 64);
        exp_fault = perm || (fails >= 3);
        exp_att   = exp_fault ? 3 : fails + 1;
        if (exp_fault) exp_o = 3'b111;
        else exp_o = {c0[0], c0[1] & ~c0[0], c1[0]};
        got = {core_a_off, core_b_off, dbg_off};
        chk(done == 1'b1, req, done, 1);
        chk(got == exp_o, req, got, exp_o);
        // R9 / R8
        chk(fault == exp_fault, exp_fault ? "R9" : "R8", fault, exp_fault);
        // R8
        chk(attempts == exp_att, "R8", attempts, exp_att);
        // R2
        chk(!addr_err, "R2", addr_err, 0);
        // R10
        chk(pre_ok, "R10", pre_ok, 1);
        snap = got;
        repeat (8) @(negedge clk);
        // R10 and R9 hold
        chk({core_a_off, core_b_off, dbg_off, done, fault} == {snap, 1'b1, exp_fault},
            exp_fault ? "R9" : "R10", {core_a_off, core_b_off, dbg_off, done, fault},
            {snap, 1'b1, exp_fault});
    endtask

    initial begin
        // sweep: all disable patterns x 0..3 failing attempts x corruption kinds
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 4; f++) begin
                logic [23:0] w0, w1;
                w0 = 24'hA5C300 | 24'(c << 2) | 24'(c & 3);
                w1 = 24'h5E1100 | 24'((c >> 2) & 1);
                run_case(w0, w1, GUARD, f, (c + f) % 5, (c + 2 * f) % 4,
                         (c & 3) == 3 ? "R6" : "R5");
            end
        end
        // R7: response on last permitted wait cycle, then one cycle too late
        run_case(24'h000002, 24'h000001, GUARD, 0, 0, 63, "R7");
        run_case(24'h000002, 24'h000001, GUARD, 0, 0, 64, "R7");
        // R4: critical words that read as the guard pattern
        run_case(GUARD, 24'h000000, GUARD, 0, 0, 1, "R4");
        run_case(24'h000000, GUARD, GUARD, 0, 0, 0, "R4");
        // R3: a guard location that never matches
        run_case(24'h000001, 24'h000000, 24'h333332, 0, 0, 2, "R3");
        // R5: upper bits ignored
        run_case(24'hFFFFFC, 24'hFFFFFE, GUARD, 1, 2, 0, "R5");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule